// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of already-sensed, already-masked interrupt sources and a processor that has one normal and one fast interrupt request line. Each source has a 3-bit priority and a handler address, both supplied by neighbouring logic. The controller raises the normal request whenever a pending source outranks the interrupt now in service. Software takes that interrupt by reading a vector register, which returns the handler address of the winning source. The read also records the winner's level on an internal stack of in-service levels.

Software writes an end-of-interrupt register when a handler finishes. That write removes the newest level from the stack, so lower-level work can be taken again. Because only a strictly higher level can raise the request while a level is in service, handlers nest naturally. If a read finds nothing eligible, it returns a programmable spurious vector and changes no state.

For edge-sensed sources, the acknowledging access pulses a per-source clear line back to the sensing logic. The fast request line passes straight through. It has its own handler register and is never prioritised or stacked. A debug protect bit makes vector reads free of side effects, so a debugger can display the register safely. In that mode a write to the vector register performs the acknowledge instead.

Top module: `vpic_core`

## Requirements
- R1: `irq` is high in a cycle exactly when some source has `src_pend` set and its priority is strictly greater than the level on top of the in-service stack, or when the stack is empty and any source is pending.
- R2: A read of address 0 with protect off returns, in the same cycle on `bus_rdata`, the handler address of the eligible source with the highest priority (7 highest, 0 lowest). Ties go to the lowest source index. The read pushes that source's priority onto the stack at the clock edge.
- R3: While a level is in service, a pending source of equal or lower priority leaves `irq` low and cannot be acknowledged. A strictly higher one raises `irq` and, when read, nests on top of the stack.
- R4: During an acknowledging access that finds an eligible winner, `ack_clr` has exactly the winner's bit set in that same cycle if the winner's `src_edge` bit is 1. Otherwise `ack_clr` is all zeros.
- R5: A write to address 2 (end of interrupt) pops the newest level. `irq` is evaluated against the remaining stack from the next cycle on.
- R6: A read of address 0 when no source is eligible returns the spurious vector, pushes nothing and pulses no `ack_clr` bit. The spurious vector is read and written at address 3.
- R7: `fiq` equals `fast_req` in every cycle. Address 1 holds the fast handler address, is read and written there, and has no effect on the stack.
- R8: When bit 0 of the debug register (address 4) is 1, a read of address 0 still returns the vector but neither pushes nor pulses `ack_clr`. A write to address 0 then performs the full acknowledge (push and clear).
- R9: An end-of-interrupt write with an empty stack changes nothing. A push with DEPTH levels already stored is dropped.
- R10: After reset the stack is empty, `irq` and `ack_clr` are low, and the spurious vector, fast handler and protect bit read as 0.
- R11: `bus_rdata` is 0 when `bus_rd` is low and on reads of addresses 2 and 5 to 7. A read of address 4 returns the protect bit in bit 0 and zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | AW | Write data |
| bus_rdata | output | AW | Read data, valid in the strobe cycle |
| src_pend | input | NSRC | Masked pending bit per source |
| src_prio | input | 3*NSRC | Priority per source, source i in bits 3i+2..3i |
| src_vec | input | AW*NSRC | Handler address per source, source i in bits AW*i+AW-1..AW*i |
| src_edge | input | NSRC | 1 when a source is edge sensed |
| fast_req | input | 1 | Fast interrupt request |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request to processor |
| ack_clr | output | NSRC | One-cycle clear pulse to an edge-sensed source |

## Verification
The bench builds the block with six sources, 16-bit addresses and the default stack depth of eight. With six sources, two of them can share a priority, which exercises the lowest-index tie break. A three-deep nest and returns through end-of-interrupt are also reachable. The narrower addresses make each handler value easy to tell apart in a mismatch line, while the full protect, spurious and empty-pop paths stay reachable.

// File: rtl/vpic_core.sv
module vpic_core #(
  parameter int NSRC  = 16,
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [AW-1:0]      bus_wdata,
  output logic [AW-1:0]      bus_rdata,
  input  logic [NSRC-1:0]    src_pend,
  input  logic [3*NSRC-1:0]  src_prio,
  input  logic [AW*NSRC-1:0] src_vec,
  input  logic [NSRC-1:0]    src_edge,
  input  logic               fast_req,
  output logic               irq,
  output logic               fiq,
  output logic [NSRC-1:0]    ack_clr
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] A_IVEC = 3'd0, A_FVEC = 3'd1, A_EOI = 3'd2, A_SPUR = 3'd3, A_DBG = 3'd4;

  logic [2:0]    lvl_stk [DEPTH];
  logic [CW-1:0] depth_q;
  logic [AW-1:0] spur_q, fvec_q;
  logic          prot_q;

  logic          empty;
  logic [2:0]    top_lvl;
  logic          win_ok;
  logic [SW-1:0] win_idx;
  logic [2:0]    win_lvl;
  logic          ack, push, pop;

  assign empty   = (depth_q == '0);
  assign top_lvl = empty ? 3'd0 : lvl_stk[IW'(depth_q - CW'(1))];

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_pend[i] && (empty || src_prio[3*i +: 3] > top_lvl) &&
          (!win_ok || src_prio[3*i +: 3] > win_lvl)) begin
        win_ok  = 1'b1;
        win_idx = SW'(i);
        win_lvl = src_prio[3*i +: 3];
      end
    end
  end

  assign irq = win_ok;
  assign fiq = fast_req;

  assign ack  = (bus_addr == A_IVEC) && ((bus_rd && !prot_q) || (bus_wr && prot_q));
  assign push = ack && win_ok && (depth_q < CW'(DEPTH));
  assign pop  = bus_wr && (bus_addr == A_EOI) && !empty && !push;
  assign ack_clr = (ack && win_ok && src_edge[win_idx]) ? (NSRC'(1) << win_idx) : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_IVEC:  bus_rdata = win_ok ? src_vec[AW*win_idx +: AW] : spur_q;
        A_FVEC:  bus_rdata = fvec_q;
        A_SPUR:  bus_rdata = spur_q;
        A_DBG:   bus_rdata = AW'(prot_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) lvl_stk[IW'(depth_q)] <= win_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      spur_q  <= '0;
      fvec_q  <= '0;
      prot_q  <= 1'b0;
    end else begin
      if (push)     depth_q <= depth_q + CW'(1);
      else if (pop) depth_q <= depth_q - CW'(1);
      if (bus_wr && bus_addr == A_FVEC) fvec_q <= bus_wdata;
      if (bus_wr && bus_addr == A_SPUR) spur_q <= bus_wdata;
      if (bus_wr && bus_addr == A_DBG)  prot_q <= bus_wdata[0];
    end
  end

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_ok && depth_q < CW'(DEPTH)) |=> (depth_q == $past(depth_q) + CW'(1)));

  p_nest_higher_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !empty) |=> (top_lvl > $past(top_lvl)));

  p_clr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr));

  p_clr_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr != '0) |-> (ack && irq));

  p_eoi_pops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == A_EOI && !empty) |=> (depth_q == $past(depth_q) - CW'(1)));

  p_spur_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == A_IVEC && !irq) |=> $stable(depth_q));

  p_fast_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq == fast_req);

  p_protect_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && bus_rd && !bus_wr && bus_addr == A_IVEC) |=> $stable(depth_q));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !bus_rd && bus_wr && bus_addr == A_EOI) |=> (depth_q == '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= CW'(DEPTH));
endmodule

// File: tb/vpic_core_bench.sv
module vpic_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 6;
  localparam int AW = 16;
  localparam int D  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [AW-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] src_pend = '0, src_edge = '0, ack_clr;
  logic [3*N-1:0] src_prio = '0;
  logic [AW*N-1:0] src_vec = '0;
  logic fast_req = 1'b0, irq, fiq;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R10";

  int stk[$];
  logic [AW-1:0] m_spur = '0, m_fvec = '0;
  bit m_prot = 0;

  vpic_core #(.NSRC(N), .AW(AW), .DEPTH(D)) u_vpic_core (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pend(src_pend), .src_prio(src_prio),
    .src_vec(src_vec), .src_edge(src_edge), .fast_req(fast_req), .irq(irq), .fiq(fiq),
    .ack_clr(ack_clr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int prio(int i);
    return int'(src_prio[3*i +: 3]);
  endfunction

  function automatic int best();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (src_pend[i] && (stk.size() == 0 || prio(i) > stk[stk.size()-1]) &&
          (b < 0 || prio(i) > prio(b))) b = i;
    return b;
  endfunction

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s actual=%h expected=%h", cur_req, tag, act, exp);
    end
  endtask

  task automatic cycle();
    int b;
    bit do_ack;
    logic [AW-1:0] e_rd;
    logic [N-1:0] e_clr;
    #1;
    b = best();
    do_ack = (bus_addr == 3'd0) && ((bus_rd && !m_prot) || (bus_wr && m_prot));
    e_rd = '0;
    if (bus_rd) begin
      case (bus_addr)
        3'd0: e_rd = (b >= 0) ? src_vec[AW*b +: AW] : m_spur;
        3'd1: e_rd = m_fvec;
        3'd3: e_rd = m_spur;
        3'd4: e_rd = AW'(m_prot);
        default: e_rd = '0;
      endcase
    end
    e_clr = (do_ack && b >= 0 && src_edge[b]) ? (N'(1) << b) : '0;
    chk("R1 irq", AW'(irq), AW'(b >= 0));
    chk("R7 fiq", AW'(fiq), AW'(fast_req));
    chk("R4 ack_clr", AW'(ack_clr), AW'(e_clr));
    chk(bus_addr == 3'd0 ? ((b >= 0) ? "R2 vector" : "R6 spurious") : "R11 rdata", bus_rdata, e_rd);
    @(posedge clk);
    if (do_ack && b >= 0 && stk.size() < D) stk.push_back(prio(b));
    else if (bus_wr && bus_addr == 3'd2 && stk.size() > 0) void'(stk.pop_back());
    if (bus_wr && bus_addr == 3'd1) m_fvec = bus_wdata;
    if (bus_wr && bus_addr == 3'd3) m_spur = bus_wdata;
    if (bus_wr && bus_addr == 3'd4) m_prot = bus_wdata[0];
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic rd(logic [2:0] a);
    bus_rd = 1'b1; bus_addr = a; cycle(); bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic wr(logic [2:0] a, logic [AW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; cycle(); bus_wr = 1'b0; bus_wdata = '0; bus_addr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) src_vec[AW*i +: AW] = AW'(16'hA000 + 16'h0110 * i);
    src_prio = {3'd0, 3'd7, 3'd1, 3'd5, 3'd5, 3'd2};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R10";
    idle(2); rd(3'd1); rd(3'd3); rd(3'd4); rd(3'd0);

    cur_req = "R11";
    wr(3'd3, 16'h5BAD); wr(3'd1, 16'hF1F0);
    rd(3'd3); rd(3'd1); rd(3'd2); rd(3'd5); rd(3'd7);

    cur_req = "R2";
    src_pend = 6'b000110; idle(1); rd(3'd0); idle(2);

    cur_req = "R3";
    src_pend = 6'b001110; idle(2);
    src_pend = 6'b011110; idle(1); rd(3'd0); idle(2);

    cur_req = "R5";
    wr(3'd2, '0); idle(2);
    src_pend = 6'b001110; idle(1);
    wr(3'd2, '0); idle(2);

    cur_req = "R9";
    src_pend = '0; idle(1);
    wr(3'd2, '0); wr(3'd2, '0);
    src_pend = 6'b000001; idle(1); rd(3'd0); wr(3'd2, '0); idle(1);

    cur_req = "R4";
    src_edge = 6'b000100;
    src_pend = 6'b000100; idle(1); rd(3'd0);
    src_pend = 6'b000000; idle(1); wr(3'd2, '0);
    src_pend = 6'b000010; rd(3'd0); wr(3'd2, '0);
    src_edge = 6'b010000; src_pend = 6'b010000; rd(3'd0); src_pend = '0; wr(3'd2, '0);

    cur_req = "R6";
    rd(3'd0); idle(1);
    src_pend = 6'b000010; rd(3'd0);
    src_pend = 6'b001011; rd(3'd0); idle(1);
    src_pend = '0; wr(3'd2, '0);
    src_pend = 6'b001000; idle(1); rd(3'd0); src_pend = '0; wr(3'd2, '0);

    cur_req = "R7";
    fast_req = 1'b1; idle(2); rd(3'd1);
    wr(3'd1, 16'h0FA5); rd(3'd1);
    src_pend = 6'b000001; idle(1);
    fast_req = 1'b0; idle(1); src_pend = '0;

    cur_req = "R8";
    wr(3'd4, 16'hFFFF); rd(3'd4);
    src_pend = 6'b010000; idle(1);
    rd(3'd0); rd(3'd0); idle(1);
    wr(3'd0, '0); idle(1);
    src_pend = '0; wr(3'd2, '0);
    wr(3'd4, 16'h0000); rd(3'd4);
    src_pend = 6'b000100; src_edge = 6'b000100; rd(3'd0); src_pend = '0; wr(3'd2, '0);
    idle(2);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule